// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

This block is a synchronous static RAM with one registered output stage and a four-beat burst engine. The array holds `DEPTH` words of two bytes each and keeps its contents through reset. Accesses start from either of two address strobes. The processor strobe can only start reads, and the master enable gates it. The controller strobe can start reads or writes, and the master enable does not gate it, although a controller strobe that arrives while the master enable is inactive takes the part out of selection. After a start, a burst-advance input steps through the burst or holds the current word, and it does the same for reads and for writes.

The data bus is split into an input, an output and an output-valid flag. The output-valid flag drops for a cycle after every edge that samples a write. It also drops whenever the output-enable input is high, and it does so at once with no clock. Byte writing has a fixed priority. The global write enable writes both bytes. Below it, the byte write enable lets the per-byte enables pick the bytes. Any other combination gives a read.

Top module: `burst_sram`

## Requirements
- R1: A read access registered on rising edge k appears on `dq_out`, with `dq_oe` high, after rising edge k+1. No read is driven after an edge whose preceding edge registered no read access.
- R2: An edge with `strobe_cpu_n` low and `ce_main_n` low starts a read at `addr`, whatever the write controls are. No byte of the array changes on that edge.
- R3: An edge with `strobe_ctl_n` low starts a cycle at `addr` when the processor strobe is not taking effect. If the write controls select any byte on that edge, it is a write of `dq_in` on the same edge. Otherwise it is a read.
- R4: While `ce_main_n` is high, a low `strobe_cpu_n` is ignored and the burst carries on. An edge with `ce_main_n` high and `strobe_ctl_n` low deselects the part, so no read is driven after the following edge.
- R5: When a strobe starts a cycle while `ce_hi` is low or `ce_lo_n` is high, the part is deselected instead. No read is driven after the following edge.
- R6: With both strobes high during an active cycle, `adv_n` low moves to the next burst address and `adv_n` high stays at the current one, for reads and for writes.
- R7: `wr_all_n` low writes both bytes. Otherwise, `wr_byte_n` low writes the bytes whose `wr_lane_n` bit is low, where bit 0 is `dq[7:0]` and bit 1 is `dq[15:8]`. Otherwise nothing is written.
- R8: After any edge that samples a write, `dq_oe` is low for that cycle. `out_en_n` high forces `dq_oe` low with no clock edge.
- R9: A burst covers four words. The upper address bits stay fixed, and the two low bits wrap. Beat i uses low bits (start+i) mod 4 when `INTERLEAVED`=0 (the default), and start XOR i otherwise.
- R10: Reset and deselection leave the part idle. While idle, an edge with both strobes high neither writes nor starts a read, until a valid strobe with active enables begins a new cycle. Reset does not clear the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of pipeline and burst state |
| addr | input | AW | Word address, sampled when a cycle begins |
| ce_main_n | input | 1 | Master chip enable, active low |
| ce_hi | input | 1 | Secondary chip enable, active high |
| ce_lo_n | input | 1 | Secondary chip enable, active low |
| strobe_cpu_n | input | 1 | Processor address strobe, active low, read-only starts |
| strobe_ctl_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| wr_all_n | input | 1 | Global write enable, active low |
| wr_byte_n | input | 1 | Byte write enable, active low |
| wr_lane_n | input | 2 | Per-byte write enables, active low |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| dq_in | input | 16 | Write data |
| dq_out | output | 16 | Read data |
| dq_oe | output | 1 | Output drivers enabled |

## Verification
Several internal faults show up at the ports one or two edges after the fault occurs. A wrong burst counter shows up as a wrong word on `dq_out` one edge after the faulty advance. A wrong decision between read and write, or between the two strobes, shows up in one of two ways: a later read returns a word that should have been left alone, or `dq_oe` stays high after an edge that sampled a write. A selection flag left set after a deselect shows up as `dq_oe` rising two edges later, when no cycle was begun. A byte-mask fault is only visible when the word is read back, so every byte-write case is followed at once by a read of the same address.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;
  localparam int LANES  = 2;
  localparam int LANE_W = 8;
  localparam int WORD_W = LANES * LANE_W;

  // Byte-write priority: global enable, then byte enable with lane selects.
  function automatic logic [LANES-1:0] lane_mask(input logic all_n,
                                                 input logic byte_n,
                                                 input logic [LANES-1:0] lane_n);
    if (!all_n)       return '1;
    else if (!byte_n) return ~lane_n;
    else              return '0;
  endfunction
endpackage

// File: rtl/burst_sram_decode.sv
module burst_sram_decode
  import burst_sram_pkg::*;
(
  input  logic             strobe_cpu_n,
  input  logic             strobe_ctl_n,
  input  logic             ce_main_n,
  input  logic             ce_hi,
  input  logic             ce_lo_n,
  input  logic             wr_all_n,
  input  logic             wr_byte_n,
  input  logic [LANES-1:0] wr_lane_n,
  output logic             new_cycle,
  output logic             begin_ev,
  output logic             desel_ev,
  output logic             begin_wr,
  output logic [LANES-1:0] wr_mask
);
  logic cpu_go;
  logic ctl_go;
  logic sel_ok;

  always_comb begin
    cpu_go    = !strobe_cpu_n && !ce_main_n;
    ctl_go    = !strobe_ctl_n && !cpu_go;
    new_cycle = cpu_go || ctl_go;
    sel_ok    = !ce_main_n && ce_hi && !ce_lo_n;
    begin_ev  = new_cycle && sel_ok;
    desel_ev  = new_cycle && !sel_ok;
    wr_mask   = lane_mask(wr_all_n, wr_byte_n, wr_lane_n);
    begin_wr  = ctl_go && (|wr_mask);
  end
endmodule

// File: rtl/burst_sram_counter.sv
module burst_sram_counter #(
  parameter int AW          = 8,
  parameter bit INTERLEAVED = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic [AW-1:0] start_addr,
  output logic [AW-1:0] cur_addr
);
  localparam int BW = 2;

  logic [AW-1:0] base_q;
  logic [AW-1:0] base_use;
  logic [BW-1:0] beat_q;
  logic [BW-1:0] beat_use;
  logic [BW-1:0] low_bits;

  always_comb begin
    base_use = load ? start_addr : base_q;
    if (load)      beat_use = '0;
    else if (step) beat_use = beat_q + 1'b1;
    else           beat_use = beat_q;
  end

  generate
    if (INTERLEAVED) begin : g_xor
      assign low_bits = base_use[BW-1:0] ^ beat_use;
    end else begin : g_add
      assign low_bits = base_use[BW-1:0] + beat_use;
    end
  endgenerate

  assign cur_addr = {base_use[AW-1:BW], low_bits};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      beat_q <= '0;
    end else begin
      base_q <= base_use;
      beat_q <= beat_use;
    end
  end
endmodule

// File: rtl/burst_sram_array.sv
module burst_sram_array
  import burst_sram_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int AW    = 8
) (
  input  logic              clk,
  input  logic [LANES-1:0]  we,
  input  logic [AW-1:0]     waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [WORD_W-1:0] rdata
);
  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] cells [DEPTH];
      logic [LANE_W-1:0] rd_q;

      always_ff @(posedge clk) begin
        if (we[g]) cells[waddr] <= wdata[g*LANE_W +: LANE_W];
        rd_q <= cells[raddr];
      end

      assign rdata[g*LANE_W +: LANE_W] = rd_q;
    end
  endgenerate
endmodule

// File: rtl/burst_sram.sv
module burst_sram
  import burst_sram_pkg::*;
#(
  parameter int DEPTH       = 256,
  parameter bit INTERLEAVED = 1'b0,
  localparam int AW         = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     addr,
  input  logic              ce_main_n,
  input  logic              ce_hi,
  input  logic              ce_lo_n,
  input  logic              strobe_cpu_n,
  input  logic              strobe_ctl_n,
  input  logic              adv_n,
  input  logic              wr_all_n,
  input  logic              wr_byte_n,
  input  logic [LANES-1:0]  wr_lane_n,
  input  logic              out_en_n,
  input  logic [WORD_W-1:0] dq_in,
  output logic [WORD_W-1:0] dq_out,
  output logic              dq_oe
);
  logic             new_cycle;
  logic             begin_ev;
  logic             desel_ev;
  logic             begin_wr;
  logic [LANES-1:0] wr_mask;
  logic             cont_ev;
  logic             wr_ev;
  logic             rd_issue;
  logic [AW-1:0]    acc_addr;
  logic [AW-1:0]    rd_addr_q;
  logic [LANES-1:0] we_lanes;

  logic active_q;
  logic rd_pending;
  logic drv_q;

  burst_sram_decode u_decode (
    .strobe_cpu_n (strobe_cpu_n),
    .strobe_ctl_n (strobe_ctl_n),
    .ce_main_n    (ce_main_n),
    .ce_hi        (ce_hi),
    .ce_lo_n      (ce_lo_n),
    .wr_all_n     (wr_all_n),
    .wr_byte_n    (wr_byte_n),
    .wr_lane_n    (wr_lane_n),
    .new_cycle    (new_cycle),
    .begin_ev     (begin_ev),
    .desel_ev     (desel_ev),
    .begin_wr     (begin_wr),
    .wr_mask      (wr_mask)
  );

  // Continue or suspend only applies inside a selected cycle.
  assign cont_ev  = !new_cycle && active_q;
  assign wr_ev    = (begin_ev && begin_wr) || (cont_ev && (|wr_mask));
  assign rd_issue = (begin_ev && !begin_wr) || (cont_ev && !(|wr_mask));
  assign we_lanes = wr_ev ? wr_mask : '0;

  burst_sram_counter #(
    .AW          (AW),
    .INTERLEAVED (INTERLEAVED)
  ) u_counter (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (begin_ev),
    .step       (cont_ev && !adv_n),
    .start_addr (addr),
    .cur_addr   (acc_addr)
  );

  burst_sram_array #(
    .DEPTH (DEPTH),
    .AW    (AW)
  ) u_array (
    .clk   (clk),
    .we    (we_lanes),
    .waddr (acc_addr),
    .wdata (dq_in),
    .raddr (rd_addr_q),
    .rdata (dq_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q   <= 1'b0;
      rd_pending <= 1'b0;
      rd_addr_q  <= '0;
      drv_q      <= 1'b0;
    end else begin
      if (begin_ev)      active_q <= 1'b1;
      else if (desel_ev) active_q <= 1'b0;
      rd_pending <= rd_issue;
      rd_addr_q  <= acc_addr;
      drv_q      <= rd_pending && !wr_ev;
    end
  end

  assign dq_oe = drv_q && !out_en_n;
endmodule

// File: rtl/burst_sram_chk.sv
module burst_sram_chk (
  input logic clk,
  input logic rst_n,
  input logic strobe_cpu_n,
  input logic strobe_ctl_n,
  input logic ce_main_n,
  input logic ce_hi,
  input logic ce_lo_n,
  input logic out_en_n,
  input logic dq_oe,
  input logic new_cycle,
  input logic wr_ev,
  input logic rd_pending,
  input logic drv_q,
  input logic active_q
);
  assert_pipe_fill_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pending |=> (drv_q || $past(wr_ev)));

  assert_pipe_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_pending |=> !drv_q);

  assert_cpu_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_cpu_n && !ce_main_n) |-> !wr_ev);

  assert_ctl_desel_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_main_n && !strobe_ctl_n) |=> (!active_q && !rd_pending));

  assert_sec_desel_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (new_cycle && !(ce_hi && !ce_lo_n)) |=> (!active_q && !rd_pending));

  assert_wr_blank_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ev |=> !dq_oe);

  assert_oe_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_en_n |-> !dq_oe);

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_q && !new_cycle) |=> !rd_pending);
endmodule

bind burst_sram burst_sram_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .strobe_cpu_n (strobe_cpu_n),
  .strobe_ctl_n (strobe_ctl_n),
  .ce_main_n    (ce_main_n),
  .ce_hi        (ce_hi),
  .ce_lo_n      (ce_lo_n),
  .out_en_n     (out_en_n),
  .dq_oe        (dq_oe),
  .new_cycle    (new_cycle),
  .wr_ev        (wr_ev),
  .rd_pending   (rd_pending),
  .drv_q        (drv_q),
  .active_q     (active_q)
);

// File: tb/burst_sram_tb.sv
`timescale 1ns/1ps
module burst_sram_tb;
  localparam int DEPTH = 256;
  localparam int AW    = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr;
  logic          ce_main_n, ce_hi, ce_lo_n;
  logic          strobe_cpu_n, strobe_ctl_n, adv_n;
  logic          wr_all_n, wr_byte_n;
  logic [1:0]    wr_lane_n;
  logic          out_en_n;
  logic [15:0]   dq_in;
  logic [15:0]   dq_out;
  logic          dq_oe;

  int  n_total = 0;
  int  n_fail  = 0;
  bit  finished = 1'b0;
  logic [15:0] mem_m [DEPTH];

  always #2 clk = ~clk;

  burst_sram #(.DEPTH(DEPTH), .INTERLEAVED(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .ce_main_n(ce_main_n),
    .ce_hi(ce_hi), .ce_lo_n(ce_lo_n), .strobe_cpu_n(strobe_cpu_n),
    .strobe_ctl_n(strobe_ctl_n), .adv_n(adv_n), .wr_all_n(wr_all_n),
    .wr_byte_n(wr_byte_n), .wr_lane_n(wr_lane_n), .out_en_n(out_en_n),
    .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  function automatic logic [15:0] pat(input int a);
    return 16'((a * 16'h0111) ^ 16'h5A3C);
  endfunction

  function automatic logic [7:0] beat_addr(input logic [7:0] b, input int i);
    logic [1:0] lo;
    lo = 2'((int'(b[1:0]) + i) % 4);
    return {b[7:2], lo};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_total++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle_in();
    addr = '0; ce_main_n = 1'b0; ce_hi = 1'b1; ce_lo_n = 1'b0;
    strobe_cpu_n = 1'b1; strobe_ctl_n = 1'b1; adv_n = 1'b1;
    wr_all_n = 1'b1; wr_byte_n = 1'b1; wr_lane_n = 2'b11;
    out_en_n = 1'b0; dq_in = '0;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic begin_rd(input logic [7:0] a);
    strobe_cpu_n = 1'b0; addr = a;
    tick();
    idle_in();
  endtask

  task automatic ctl_wr(input logic [7:0] a, input logic [15:0] d,
                        input logic all_n, input logic byte_n, input logic [1:0] lanes);
    strobe_ctl_n = 1'b0; addr = a; dq_in = d;
    wr_all_n = all_n; wr_byte_n = byte_n; wr_lane_n = lanes;
    tick();
    idle_in();
  endtask

  task automatic read_word(input logic [7:0] a, input string tag);
    begin_rd(a);
    tick();
    chk(dq_oe === 1'b1 && dq_out === mem_m[a], tag, {15'd0, dq_oe, dq_out}, {16'd1, mem_m[a]});
  endtask

  initial begin
    #400000;
    if (!finished) begin
      n_total++;
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
    end
  end

  initial begin
    idle_in();
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R10: idle after reset, no drive
    chk(dq_oe === 1'b0, "R10 reset idle oe", {31'd0, dq_oe}, 32'd0);
    tick();
    chk(dq_oe === 1'b0, "R10 idle stays quiet", {31'd0, dq_oe}, 32'd0);

    // R3/R7/R8: fill with controller-strobe global writes
    for (int a = 0; a < DEPTH; a++) begin
      ctl_wr(8'(a), pat(a), 1'b0, 1'b1, 2'b11);
      mem_m[a] = pat(a);
      chk(dq_oe === 1'b0, "R8 oe low after write edge", {31'd0, dq_oe}, 32'd0);
    end

    // R1/R6/R9: four-beat bursts from every start address
    for (int b = 0; b < DEPTH; b++) begin
      begin_rd(8'(b));
      for (int i = 0; i < 3; i++) begin
        adv_n = 1'b0;
        tick();
        adv_n = 1'b1;
        chk(dq_oe === 1'b1 && dq_out === mem_m[beat_addr(8'(b), i)], "R1 R9 burst beat",
            {15'd0, dq_oe, dq_out}, {16'd1, mem_m[beat_addr(8'(b), i)]});
      end
      tick();
      chk(dq_out === mem_m[beat_addr(8'(b), 3)], "R9 wrap last beat",
          {16'd0, dq_out}, {16'd0, mem_m[beat_addr(8'(b), 3)]});
    end

    // R2: processor strobe with global write asserted reads
    strobe_cpu_n = 1'b0; addr = 8'h21; wr_all_n = 1'b0; dq_in = 16'hDEAD;
    tick();
    idle_in();
    tick();
    chk(dq_oe === 1'b1 && dq_out === mem_m[8'h21], "R2 cpu strobe is read",
        {15'd0, dq_oe, dq_out}, {16'd1, mem_m[8'h21]});
    read_word(8'h21, "R2 array untouched");

    // R3: controller strobe with write controls idle is a read
    strobe_ctl_n = 1'b0; addr = 8'h33;
    tick();
    idle_in();
    tick();
    chk(dq_oe === 1'b1 && dq_out === mem_m[8'h33], "R3 ctl strobe read",
        {15'd0, dq_oe, dq_out}, {16'd1, mem_m[8'h33]});
    // R3: both strobes low with master on -> processor wins, no write
    strobe_ctl_n = 1'b0; strobe_cpu_n = 1'b0; addr = 8'h34;
    wr_all_n = 1'b0; dq_in = 16'hBEEF;
    tick();
    idle_in();
    read_word(8'h34, "R3 processor strobe wins");

    // R7: byte writes
    ctl_wr(8'h50, 16'h1122, 1'b1, 1'b0, 2'b10);
    mem_m[8'h50][7:0] = 8'h22;
    read_word(8'h50, "R7 low byte only");
    ctl_wr(8'h51, 16'h3344, 1'b1, 1'b0, 2'b01);
    mem_m[8'h51][15:8] = 8'h33;
    read_word(8'h51, "R7 high byte only");
    ctl_wr(8'h52, 16'h5566, 1'b1, 1'b1, 2'b00);
    read_word(8'h52, "R7 byte enable off is read");
    ctl_wr(8'h53, 16'h7788, 1'b0, 1'b1, 2'b11);
    mem_m[8'h53] = 16'h7788;
    read_word(8'h53, "R7 global overrides lanes");

    // R6: suspend read holds the current word
    begin_rd(8'h60);
    tick();
    tick();
    chk(dq_out === mem_m[8'h60], "R6 suspend read holds", {16'd0, dq_out}, {16'd0, mem_m[8'h60]});

    // R6: burst write continue then suspend write
    ctl_wr(8'h6E, 16'hA001, 1'b0, 1'b1, 2'b11);
    mem_m[8'h6E] = 16'hA001;
    adv_n = 1'b0; wr_all_n = 1'b0; dq_in = 16'hA002;
    tick();
    idle_in();
    wr_all_n = 1'b0; dq_in = 16'hA003;
    tick();
    idle_in();
    mem_m[8'h6F] = 16'hA003;
    read_word(8'h6E, "R6 burst write first");
    read_word(8'h6F, "R6 suspend write overwrote next");

    // R8: write during an active read blanks the outputs
    begin_rd(8'h80);
    adv_n = 1'b0; wr_all_n = 1'b0; dq_in = 16'hC0DE;
    tick();
    idle_in();
    mem_m[8'h81] = 16'hC0DE;
    chk(dq_oe === 1'b0, "R8 write after read blanks", {31'd0, dq_oe}, 32'd0);
    read_word(8'h81, "R8 continue write landed");

    // R8: asynchronous output enable
    #1 out_en_n = 1'b1;
    #0.5;
    chk(dq_oe === 1'b0, "R8 async disable", {31'd0, dq_oe}, 32'd0);
    out_en_n = 1'b0;
    #0.5;
    chk(dq_oe === 1'b1, "R8 async enable", {31'd0, dq_oe}, 32'd1);
    tick();

    // R4: processor strobe blocked by master enable, burst goes on
    begin_rd(8'h40);
    strobe_cpu_n = 1'b0; ce_main_n = 1'b1; addr = 8'h90; adv_n = 1'b0;
    tick();
    idle_in();
    tick();
    chk(dq_oe === 1'b1 && dq_out === mem_m[8'h41], "R4 blocked strobe continues",
        {15'd0, dq_oe, dq_out}, {16'd1, mem_m[8'h41]});

    // R4: controller strobe with master off deselects
    read_word(8'h42, "R4 setup read");
    ce_main_n = 1'b1; strobe_ctl_n = 1'b0;
    tick();
    idle_in();
    tick();
    chk(dq_oe === 1'b0, "R4 ctl deselect", {31'd0, dq_oe}, 32'd0);

    // R5: secondary enables inactive
    read_word(8'h43, "R5 setup read");
    strobe_cpu_n = 1'b0; ce_hi = 1'b0; addr = 8'h44;
    tick();
    idle_in();
    tick();
    chk(dq_oe === 1'b0, "R5 ce_hi low deselects", {31'd0, dq_oe}, 32'd0);
    read_word(8'h45, "R5 setup read 2");
    strobe_ctl_n = 1'b0; ce_lo_n = 1'b1; addr = 8'h46;
    tick();
    idle_in();
    tick();
    chk(dq_oe === 1'b0, "R5 ce_lo_n high deselects", {31'd0, dq_oe}, 32'd0);

    // R10: idle part ignores continue writes
    read_word(8'h77, "R10 setup read");
    ce_main_n = 1'b1; strobe_ctl_n = 1'b0;
    tick();
    idle_in();
    adv_n = 1'b0; wr_all_n = 1'b0; dq_in = 16'hFFFF;
    tick();
    idle_in();
    chk(dq_oe === 1'b0, "R10 idle no drive", {31'd0, dq_oe}, 32'd0);
    read_word(8'h74, "R10 next word unchanged");
    read_word(8'h77, "R10 current word unchanged");

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule